// File: doc/BRIEF.md
# Logic Analyzer Capture Rate Synchronizer

This block forms the sample-valid strobe and the aligned sample word for a logic-analyzer capture path. That path shares its clock with a decimating ADC capture path. A rate-source input picks where the strobe comes from:

- **Local mode:** the strobe comes from a local programmable divider.
- **ADC mode:** the strobe is slaved to the ADC path's decimated valid.

ADC mode removes the one-sample mismatch that two independently started rate generators leave behind. Reset cannot remove that mismatch. Slaving is only meaningful when software has set both paths to the same effective rate, including any ADC oversampling.

The selected strobe and the analyzer data word both pass through one shift register. The stage read out sets a delay of tap + 1 clocks. The tap count comes from one of two places:

- **Manual mode:** a manual tap input.
- **Automatic mode:** a lookup of the current decimation setting.

This lets the analyzer samples be lined up with the delayed ADC samples.

Top module: `la_rate_sync`

## Requirements
- R1: While `rst_n` is low, `la_valid_o` is 0 and `la_data_o` is all zeros. The local divider count restarts from 0.
- R2: With `rate_src_i` = 0 (local mode), the strobe entering the delay line is high in every cycle where the divider count is at least `rate_div_i`. The count then returns to 0, so a steady divisor D gives one strobe every D+1 clocks, with the first one D clocks after reset.
- R3: When `rate_div_i` is lowered below the running count, the divider fires in the very next cycle and restarts from 0.
- R4: With `rate_src_i` = 1 (ADC mode), `adc_valid_i` is the strobe entering the delay line. The local divider has no effect on `la_valid_o`.
- R5: With `tap_auto_i` = 0, the tap count is `tap_man_i` (0 to 7). `la_data_o` equals `la_data_i` from tap+1 clocks earlier.
- R6: With `tap_auto_i` = 1, the tap count equals the decimation code `dec_sel_i` (codes 0, 1, 2 and 3 give 0, 1, 2 and 3 taps). `tap_man_i` is ignored.
- R7: `la_valid_o` is delayed by exactly the same number of clocks as `la_data_o`, so a strobe and its data word leave the block in the same cycle.
- R8: The data word shifts every clock whether or not a strobe is present. With no strobe, `la_data_o` still tracks the delayed input while `la_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_src_i | input | 1 | 0: local divider drives the strobe, 1: ADC valid drives it |
| rate_div_i | input | DIV_W | Local divisor; strobe period is value + 1 clocks |
| adc_valid_i | input | 1 | Decimated valid strobe from the ADC path |
| tap_auto_i | input | 1 | 0: manual tap count, 1: tap count from decimation code |
| tap_man_i | input | TAP_W | Manual tap count |
| dec_sel_i | input | DEC_W | Current decimation setting code |
| la_data_i | input | DATA_W | Logic-analyzer sample word |
| la_valid_o | output | 1 | Delayed sample-valid strobe |
| la_data_o | output | DATA_W | Delayed sample word |

## Verification
The main function is driven through vectors that cover both strobe sources and both tap modes:

- In local mode, divisors of 0, 1, 3, 5 and 7 separate an off-by-one in the wrap compare from a correct period.
- In ADC mode, an irregular ADC valid pattern would expose any leak of the local divider into the output.
- Manual taps at 0, 1, 2, 4 and 7, and automatic codes 0, 2 and 3 with a conflicting manual value, show whether the right stage is read and whether the unused tap source is truly ignored.

Directed cases cover the rest:

- a divisor lowered under the running count;
- a long stretch with no strobe, showing that the data still shifts;
- a reset in the middle of a run, showing that the pipeline clears.

// File: rtl/la_rs_pkg.sv
package la_rs_pkg;

    typedef enum logic {
        SRC_LOCAL = 1'b0,
        SRC_ADC   = 1'b1
    } rate_src_e;

    typedef enum logic {
        TAP_MANUAL = 1'b0,
        TAP_AUTO   = 1'b1
    } tap_mode_e;

endpackage

// File: rtl/la_rs_divider.sv
module la_rs_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             stb_o,
    output logic [DIV_W-1:0] cnt_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t state_d, state_q;
    logic       wrap;

    always_comb begin
        // Fire on >= so a divisor lowered below the count wraps at once.
        wrap    = (state_q.cnt >= div_i);
        state_d = state_q;
        if (wrap) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stb_o = wrap;
    assign cnt_o = state_q.cnt;

endmodule

// File: rtl/la_rs_tapsel.sv
module la_rs_tapsel
    import la_rs_pkg::*;
#(
    parameter int TAP_W   = 3,
    parameter int DEC_W   = 2,
    parameter int MAX_TAP = 7
) (
    input  logic             mode_i,
    input  logic [TAP_W-1:0] man_i,
    input  logic [DEC_W-1:0] dec_i,
    output logic [TAP_W-1:0] tap_o
);
    logic [TAP_W-1:0] auto_tap;

    // Decimation code maps straight to a tap count, clamped to the chain.
    always_comb begin
        if (int'(dec_i) > MAX_TAP) begin
            auto_tap = TAP_W'(MAX_TAP);
        end else begin
            auto_tap = TAP_W'(dec_i);
        end
    end

    always_comb begin
        if (tap_mode_e'(mode_i) == TAP_AUTO) begin
            tap_o = auto_tap;
        end else begin
            tap_o = man_i;
        end
    end

endmodule

// File: rtl/la_rs_delay.sv
module la_rs_delay #(
    parameter int DATA_W = 16,
    parameter int STAGES = 8,
    parameter int TAP_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] dat_i,
    input  logic [TAP_W-1:0]  tap_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] dat_o
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } smp_t;

    typedef struct packed {
        smp_t [STAGES-1:0] stg;
    } chain_t;

    chain_t chain_d, chain_q;
    smp_t   pick;

    always_comb begin
        chain_d = chain_q;
        chain_d.stg[0].vld = vld_i;
        chain_d.stg[0].dat = dat_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d.stg[k] = chain_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    // Strobe and data are read from the same stage, so they stay aligned.
    generate
        if ((1 << TAP_W) > STAGES) begin : g_clamp
            always_comb begin
                if (int'(tap_i) >= STAGES) begin
                    pick = chain_q.stg[STAGES-1];
                end else begin
                    pick = chain_q.stg[tap_i];
                end
            end
        end else begin : g_direct
            always_comb begin
                pick = chain_q.stg[tap_i];
            end
        end
    endgenerate

    assign vld_o = pick.vld;
    assign dat_o = pick.dat;

endmodule

// File: rtl/la_rate_sync.sv
module la_rate_sync
    import la_rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int STAGES = 8,
    parameter int DEC_W  = 2,
    localparam int TAP_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_src_i,
    input  logic [DIV_W-1:0]  rate_div_i,
    input  logic              adc_valid_i,
    input  logic              tap_auto_i,
    input  logic [TAP_W-1:0]  tap_man_i,
    input  logic [DEC_W-1:0]  dec_sel_i,
    input  logic [DATA_W-1:0] la_data_i,
    output logic              la_valid_o,
    output logic [DATA_W-1:0] la_data_o
);
    logic             loc_stb;
    logic [DIV_W-1:0] div_cnt;
    logic [TAP_W-1:0] tap_eff;
    logic             src_vld;

    la_rs_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div_i (rate_div_i),
        .stb_o (loc_stb),
        .cnt_o (div_cnt)
    );

    la_rs_tapsel #(
        .TAP_W   (TAP_W),
        .DEC_W   (DEC_W),
        .MAX_TAP (STAGES - 1)
    ) u_tap (
        .mode_i (tap_auto_i),
        .man_i  (tap_man_i),
        .dec_i  (dec_sel_i),
        .tap_o  (tap_eff)
    );

    always_comb begin
        if (rate_src_e'(rate_src_i) == SRC_ADC) begin
            src_vld = adc_valid_i;
        end else begin
            src_vld = loc_stb;
        end
    end

    la_rs_delay #(
        .DATA_W (DATA_W),
        .STAGES (STAGES),
        .TAP_W  (TAP_W)
    ) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (src_vld),
        .dat_i (la_data_i),
        .tap_i (tap_eff),
        .vld_o (la_valid_o),
        .dat_o (la_data_o)
    );

endmodule

// File: rtl/la_rs_checker.sv
module la_rs_checker #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int DEC_W  = 2,
    parameter int TAP_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rate_src_i,
    input logic              adc_valid_i,
    input logic [DIV_W-1:0]  rate_div_i,
    input logic              tap_auto_i,
    input logic [DEC_W-1:0]  dec_sel_i,
    input logic [DATA_W-1:0] la_data_i,
    input logic              la_valid_o,
    input logic [DATA_W-1:0] la_data_o,
    input logic              loc_stb,
    input logic [DIV_W-1:0]  div_cnt,
    input logic [TAP_W-1:0]  tap_eff
);
    AST_LOCAL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_stb && rate_div_i != '0) |=> (!loc_stb || rate_div_i == '0)); // R2

    AST_LOCAL_DRIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rate_src_i) && tap_eff == '0)
            |-> (la_valid_o == $past(loc_stb))); // R2

    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cnt >= rate_div_i) |=> (div_cnt == '0)); // R3

    AST_ADC_DRIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rate_src_i) && tap_eff == '0)
            |-> (la_valid_o == $past(adc_valid_i))); // R4

    AST_ZERO_TAP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tap_eff == '0) |-> (la_data_o == $past(la_data_i))); // R5

    AST_AUTO_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && tap_auto_i && dec_sel_i == DEC_W'(1))
            |-> (la_data_o == $past(la_data_i, 2))); // R6

endmodule

bind la_rate_sync la_rs_checker #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .DEC_W  (DEC_W),
    .TAP_W  (TAP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_src_i  (rate_src_i),
    .adc_valid_i (adc_valid_i),
    .rate_div_i  (rate_div_i),
    .tap_auto_i  (tap_auto_i),
    .dec_sel_i   (dec_sel_i),
    .la_data_i   (la_data_i),
    .la_valid_o  (la_valid_o),
    .la_data_o   (la_data_o),
    .loc_stb     (loc_stb),
    .div_cnt     (div_cnt),
    .tap_eff     (tap_eff)
);

// File: tb/tb_la_rate_sync.sv
module tb_la_rate_sync;

    localparam int DATA_W = 16;
    localparam int DIV_W  = 8;
    localparam int STAGES = 8;
    localparam int DEC_W  = 2;
    localparam int TAP_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rate_src_i = 1'b0;
    logic [DIV_W-1:0]  rate_div_i = '0;
    logic              adc_valid_i = 1'b0;
    logic              tap_auto_i = 1'b0;
    logic [TAP_W-1:0]  tap_man_i = '0;
    logic [DEC_W-1:0]  dec_sel_i = '0;
    logic [DATA_W-1:0] la_data_i = '0;
    logic              la_valid_o;
    logic [DATA_W-1:0] la_data_o;

    always #5 clk = ~clk;

    la_rate_sync #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W),
        .STAGES (STAGES),
        .DEC_W  (DEC_W)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_src_i  (rate_src_i),
        .rate_div_i  (rate_div_i),
        .adc_valid_i (adc_valid_i),
        .tap_auto_i  (tap_auto_i),
        .tap_man_i   (tap_man_i),
        .dec_sel_i   (dec_sel_i),
        .la_data_i   (la_data_i),
        .la_valid_o  (la_valid_o),
        .la_data_o   (la_data_o)
    );

    typedef struct packed {
        logic             src;
        logic [DIV_W-1:0] div;
        logic             aut;
        logic [TAP_W-1:0] man;
        logic [DEC_W-1:0] dec;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{src:1'b0, div:8'd0, aut:1'b0, man:3'd0, dec:2'd0},
        '{src:1'b0, div:8'd3, aut:1'b0, man:3'd2, dec:2'd1},
        '{src:1'b0, div:8'd5, aut:1'b1, man:3'd6, dec:2'd3},
        '{src:1'b1, div:8'd2, aut:1'b0, man:3'd1, dec:2'd0},
        '{src:1'b1, div:8'd1, aut:1'b1, man:3'd7, dec:2'd2},
        '{src:1'b0, div:8'd1, aut:1'b0, man:3'd7, dec:2'd3},
        '{src:1'b0, div:8'd7, aut:1'b1, man:3'd5, dec:2'd0},
        '{src:1'b1, div:8'd0, aut:1'b0, man:3'd4, dec:2'd1}
    };
    localparam string VEC_REQ [NVEC] = '{
        "R2 R5", "R2 R5 R7", "R2 R6", "R4 R5 R7",
        "R4 R6", "R2 R5 R7", "R2 R6", "R4 R5 R7"
    };

    int               n_tests = 0;
    int               n_fail  = 0;
    logic             hist_v [STAGES];
    logic [DATA_W-1:0] hist_d [STAGES];
    int               cnt_m = 0;
    int               tap_m = 0;
    int               cyc   = 0;

    task automatic model_clear();
        for (int k = 0; k < STAGES; k++) begin
            hist_v[k] = 1'b0;
            hist_d[k] = '0;
        end
        cnt_m = 0;
    endtask

    task automatic check_out(input string req);
        n_tests++;
        if (la_valid_o !== hist_v[tap_m] || la_data_o !== hist_d[tap_m]) begin
            n_fail++;
            $display("FAIL %s: valid act=%0b exp=%0b data act=%h exp=%h (tap %0d)",
                     req, la_valid_o, hist_v[tap_m], la_data_o, hist_d[tap_m], tap_m);
        end
    endtask

    // Drive one cycle just after a falling edge; check at the next falling edge.
    task automatic step(input vec_t v, input logic adcv, input logic [DATA_W-1:0] dat,
                        input string req);
        logic vin;
        logic lstb;
        rate_src_i  = v.src;
        rate_div_i  = v.div;
        tap_auto_i  = v.aut;
        tap_man_i   = v.man;
        dec_sel_i   = v.dec;
        adc_valid_i = adcv;
        la_data_i   = dat;
        tap_m = v.aut ? int'(v.dec) : int'(v.man);
        lstb  = (cnt_m >= int'(v.div));
        vin   = v.src ? adcv : lstb;
        @(posedge clk);
        for (int k = STAGES - 1; k > 0; k--) begin
            hist_v[k] = hist_v[k-1];
            hist_d[k] = hist_d[k-1];
        end
        hist_v[0] = vin;
        hist_d[0] = dat;
        cnt_m = lstb ? 0 : cnt_m + 1;
        @(negedge clk);
        check_out(req);
        cyc++;
    endtask

    task automatic check_reset(input string req);
        n_tests++;
        if (la_valid_o !== 1'b0 || la_data_o !== '0) begin
            n_fail++;
            $display("FAIL %s: in reset valid act=%0b exp=0 data act=%h exp=0000",
                     req, la_valid_o, la_data_o);
        end
    endtask

    initial begin
        vec_t v;
        model_clear();
        tap_m = 0;
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        check_reset("R1");
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            for (int j = 0; j < 20; j++) begin
                step(VECS[i], ((cyc * 5) % 7) < 3,
                     DATA_W'(cyc * 16'h1357) ^ 16'h00A5, VEC_REQ[i]);
            end
        end

        // R3: divisor lowered under the running count
        v = '{src:1'b0, div:8'd9, aut:1'b0, man:3'd0, dec:2'd0};
        for (int j = 0; j < 13; j++) step(v, 1'b0, DATA_W'(16'h4000 + j), "R3");
        v.div = 8'd2;
        for (int j = 0; j < 8; j++) step(v, 1'b0, DATA_W'(16'h4100 + j), "R3");

        // R8: data keeps shifting with no strobe
        v = '{src:1'b0, div:8'd200, aut:1'b0, man:3'd3, dec:2'd0};
        for (int j = 0; j < 14; j++) step(v, 1'b0, DATA_W'(16'hBEE0 + j * 3), "R8");

        // R7: single ADC strobe at the deepest tap leaves with its own word
        v = '{src:1'b1, div:8'd0, aut:1'b0, man:3'd7, dec:2'd0};
        for (int j = 0; j < 12; j++) step(v, (j == 2), DATA_W'(16'h7700 + j), "R7");

        // R6: manual value ignored in auto mode, code 3
        v = '{src:1'b1, div:8'd4, aut:1'b1, man:3'd6, dec:2'd3};
        for (int j = 0; j < 10; j++) step(v, (j % 2 == 0), DATA_W'(16'h6600 + j), "R6");

        // R1: reset in mid-run clears the pipeline and the divider
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("R1");
        @(negedge clk);
        check_reset("R1");
        model_clear();
        rst_n = 1'b1;
        v = '{src:1'b0, div:8'd3, aut:1'b0, man:3'd0, dec:2'd0};
        for (int j = 0; j < 10; j++) step(v, 1'b0, DATA_W'(16'h1100 + j), "R1 R2");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule